// File: doc/BRIEF.md
# Chunked I2C Master Transfer Sequencer

This block turns one I2C message of any length up to 2^LEN_W-1 bytes into a series of hardware transfers. Each transfer moves at most BUF_BYTES bytes (four by default) through a small master data buffer. For every transfer the sequencer presents a control word to a bit-level bus engine. The control word holds the byte count minus one, a chain flag that keeps the bus held between pieces, a repeated-start request, the direction, and the formatted target address. The bus engine is outside the block. It appears here only as a start pulse and a done handshake that reports how many bytes it moved and whether it saw a bus error.

Software-level callers hand the block one message at a time. A multi-message combined transfer is marked by two flags. `msg_first` opens the combined transfer. `msg_more` says that another message follows. The block checks each request before it starts:
- On the first message it makes sure the bus is free, forcing a soft reset if needed.
- During each piece it watches for a short count, a bus error or a missing completion, and recovers with an abort, an error clear, a buffer flush or a soft reset as the case needs.

When a message ends, the block reports a result code and the number of bytes in completed pieces.

Top module: `i2c_chunk_seq`

## Requirements
- R1: A message of length L is sent as ceil(L/BUF_BYTES) engine starts. Every piece carries BUF_BYTES bytes except the last, which carries the remainder.
- R2: `eng_tct` equals the byte count of the current piece minus one while `eng_start` is high.
- R3: `eng_chain` is 1 on every piece except the last piece of a message.
- R4: On the last piece, `eng_rstart` is 1 exactly when `msg_more` was 1 for that message. It is 0 on every other piece.
- R5: For a write, byte k of a piece (message byte offset+k) is taken from the write stream in order and sits in `eng_wbuf[8k+7:8k]` when `eng_start` rises. `wr_ready` is high only while the piece is being loaded.
- R6: For a read, after a successful piece its bytes leave on `rd_data` with `rd_valid`, one per cycle, lane 0 (`eng_rbuf[7:0]`) first. `rd_valid` and `wr_ready` are never high together.
- R7: With 7-bit addressing, `eng_amode`=0, `eng_addr_lo`={addr[6:0],0} and `eng_addr_hi`=0. With 10-bit addressing, `eng_amode`=1, `eng_addr_lo`=addr[7:0] and `eng_addr_hi`=0xF0 | (addr[9:8]<<1).
- R8: A request is rejected with status 1 and no engine start if any of these holds: the length is 0; a 7-bit address is above 0x7F; or a non-first message differs in address or addressing mode from the first message of its combined transfer.
- R9: On a first message with the bus free, `eng_flush` pulses once before loading. With the bus busy, `eng_sreset` pulses once. If the bus is then still busy, the message ends with status 2 and no engine start. Non-first messages skip this check.
- R10: If the engine reports a count other than the requested one, the status is 3. `eng_abort` pulses once, unless the piece was the last piece of a message with `msg_more`=0.
- R11: If the engine reports an error, one cycle follows with `eng_err_clr` and `eng_flush` high, and `eng_sreset` also high if the bus is not free. The status is then 5.
- R12: If no `eng_done` arrives within TIMEOUT_CYC cycles of waiting, `eng_abort` pulses once and the status is 4.
- R13: Every accepted or rejected request ends with a one-cycle `msg_done`. A full success reports status 0 and `msg_count`=L. `msg_count` otherwise counts only the bytes of pieces that completed. After reset all strobes are low and the status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | Request pulse, taken while idle |
| msg_first | input | 1 | Message opens a combined transfer |
| msg_more | input | 1 | Another message of the same transfer follows |
| msg_ten | input | 1 | 10-bit addressing |
| msg_read | input | 1 | Read direction |
| msg_addr | input | 10 | Target address |
| msg_len | input | LEN_W | Message length in bytes |
| wr_data | input | 8 | Write byte stream |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle when valid |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte strobe |
| msg_done | output | 1 | Message finished pulse |
| msg_status | output | 3 | Result: 0 ok, 1 rejected, 2 bus stuck, 3 short, 4 timeout, 5 bus error |
| msg_count | output | LEN_W | Bytes in completed pieces |
| eng_start | output | 1 | Start one piece |
| eng_tct | output | CM_W | Piece byte count minus one |
| eng_chain | output | 1 | Hold bus after this piece |
| eng_rstart | output | 1 | Repeated start after this piece |
| eng_rw | output | 1 | Piece direction, 1 = read |
| eng_amode | output | 1 | 10-bit address mode |
| eng_addr_lo | output | 8 | Low address byte |
| eng_addr_hi | output | 8 | High address byte |
| eng_wbuf | output | 8*BUF_BYTES | Master data buffer for writes |
| eng_done | input | 1 | Piece complete |
| eng_err | input | 1 | Bus error on the piece |
| eng_cnt | input | CNT_W | Bytes moved by the piece |
| eng_rbuf | input | 8*BUF_BYTES | Master data buffer after a read |
| bus_free | input | 1 | Bus state is free |
| eng_abort | output | 1 | Halt the engine |
| eng_flush | output | 1 | Flush the data buffer |
| eng_err_clr | output | 1 | Clear engine error flags |
| eng_sreset | output | 1 | Soft reset of the engine |

## Verification
The assertions watch the strobe discipline on every cycle:
- single-cycle starts and completions;
- an abort or error clear always followed at once by completion with a failure code;
- no completion straight after a start;
- no read strobe during loading;
- no start or completion right after a pre-transfer soft reset.

Only the bench scenarios can show the arithmetic. This covers the piece count and per-piece control word for every length from 1 to 9, and the byte ordering in both directions. It also covers the formatted 10-bit address, and the choice of recovery action. That choice depends on the bus state and on whether a short piece was the final one.

// File: rtl/i2c_chunk_seq_pkg.sv
package i2c_chunk_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SRST,
    ST_CHK,
    ST_FLUSH,
    ST_LOAD,
    ST_ISSUE,
    ST_WAIT,
    ST_UNLOAD,
    ST_ABORT,
    ST_RECOV,
    ST_DONE
  } seq_state_t;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_BADREQ  = 3'd1,
    RES_STUCK   = 3'd2,
    RES_SHORT   = 3'd3,
    RES_TIMEOUT = 3'd4,
    RES_BUSERR  = 3'd5
  } seq_res_t;

endpackage

// File: rtl/i2c_chunk_plan.sv
// Piece sizing: how many bytes the current piece carries and whether it is last.
module i2c_chunk_plan #(
  parameter int LEN_W     = 8,
  parameter int BUF_BYTES = 4,
  parameter int CNT_W     = 3,
  parameter int CM_W      = 2
) (
  input  logic [LEN_W-1:0] rem,
  output logic [CNT_W-1:0] cnt,
  output logic [CM_W-1:0]  cnt_m1,
  output logic             last
);
  localparam logic [LEN_W-1:0] BUF_L = LEN_W'(BUF_BYTES);
  localparam logic [CNT_W-1:0] BUF_C = CNT_W'(BUF_BYTES);

  always_comb begin
    last   = (rem <= BUF_L);
    cnt    = last ? CNT_W'(rem) : BUF_C;
    cnt_m1 = CM_W'(cnt - CNT_W'(1));
  end
endmodule

// File: rtl/i2c_addr_fmt.sv
// Target address formatting for 7-bit and 10-bit modes.
module i2c_addr_fmt (
  input  logic [9:0] addr,
  input  logic       ten,
  output logic       amode,
  output logic [7:0] lo,
  output logic [7:0] hi
);
  always_comb begin
    amode = ten;
    if (ten) begin
      lo = addr[7:0];
      hi = {5'b11110, addr[9:8], 1'b0};
    end else begin
      lo = {addr[6:0], 1'b0};
      hi = 8'h00;
    end
  end
endmodule

// File: rtl/i2c_chunk_timer.sv
// Counts waiting cycles of one piece; flags expiry on the last allowed cycle.
module i2c_chunk_timer #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    expired = run && (cnt_q == LIMIT);
    if (!run)         cnt_d = '0;
    else if (expired) cnt_d = cnt_q;
    else              cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_chunk_seq.sv
module i2c_chunk_seq
  import i2c_chunk_seq_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int BUF_BYTES   = 4,
  parameter int TIMEOUT_CYC = 64,
  localparam int CNT_W      = $clog2(BUF_BYTES + 1),
  localparam int CM_W       = $clog2(BUF_BYTES),
  localparam int BUF_W      = 8 * BUF_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic             msg_first,
  input  logic             msg_more,
  input  logic             msg_ten,
  input  logic             msg_read,
  input  logic [9:0]       msg_addr,
  input  logic [LEN_W-1:0] msg_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             msg_done,
  output logic [2:0]       msg_status,
  output logic [LEN_W-1:0] msg_count,
  output logic             eng_start,
  output logic [CM_W-1:0]  eng_tct,
  output logic             eng_chain,
  output logic             eng_rstart,
  output logic             eng_rw,
  output logic             eng_amode,
  output logic [7:0]       eng_addr_lo,
  output logic [7:0]       eng_addr_hi,
  output logic [BUF_W-1:0] eng_wbuf,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic [CNT_W-1:0] eng_cnt,
  input  logic [BUF_W-1:0] eng_rbuf,
  input  logic             bus_free,
  output logic             eng_abort,
  output logic             eng_flush,
  output logic             eng_err_clr,
  output logic             eng_sreset
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  seq_state_t       st_q, st_d;
  seq_res_t         res_q, res_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [CM_W-1:0]  idx_q, idx_d;
  logic [9:0]       addr_q, ref_addr_q;
  logic             ten_q, ref_ten_q, read_q, more_q;
  logic [BUF_W-1:0] rbuf_q;

  logic             ld_msg, ld_ref, ld_rbuf, req_bad, expired;
  logic [CNT_W-1:0] pc_cnt;
  logic [CM_W-1:0]  pc_m1;
  logic             pc_last;

  i2c_chunk_plan #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .CM_W(CM_W)) u_plan (
    .rem(rem_q), .cnt(pc_cnt), .cnt_m1(pc_m1), .last(pc_last)
  );

  i2c_addr_fmt u_afmt (
    .addr(addr_q), .ten(ten_q), .amode(eng_amode), .lo(eng_addr_lo), .hi(eng_addr_hi)
  );

  i2c_chunk_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(arst_n), .run(st_q == ST_WAIT), .expired(expired)
  );

  // request screening
  always_comb begin
    req_bad = (msg_len == '0)
            || (!msg_ten && (msg_addr[9:7] != 3'b000))
            || (!msg_first && ((msg_addr != ref_addr_q) || (msg_ten != ref_ten_q)));
  end

  assign ld_msg = (st_q == ST_IDLE) && msg_start;
  assign ld_ref = ld_msg && msg_first && !req_bad;

  // next state
  always_comb begin
    st_d        = st_q;
    res_d       = res_q;
    rem_d       = rem_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    ld_rbuf     = 1'b0;
    wr_ready    = 1'b0;
    rd_valid    = 1'b0;
    msg_done    = 1'b0;
    eng_start   = 1'b0;
    eng_abort   = 1'b0;
    eng_flush   = 1'b0;
    eng_err_clr = 1'b0;
    eng_sreset  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (msg_start) begin
        rem_d = msg_len;
        cnt_d = '0;
        idx_d = '0;
        res_d = RES_OK;
        if (req_bad) begin
          res_d = RES_BADREQ;
          st_d  = ST_DONE;
        end else if (msg_first) begin
          st_d = bus_free ? ST_FLUSH : ST_SRST;
        end else begin
          st_d = ST_LOAD;
        end
      end
      ST_SRST: begin
        eng_sreset = 1'b1;
        st_d       = ST_CHK;
      end
      ST_CHK: begin
        if (bus_free) st_d = ST_LOAD;
        else begin
          res_d = RES_STUCK;
          st_d  = ST_DONE;
        end
      end
      ST_FLUSH: begin
        eng_flush = 1'b1;
        st_d      = ST_LOAD;
      end
      ST_LOAD: begin
        if (read_q) st_d = ST_ISSUE;
        else begin
          wr_ready = 1'b1;
          if (wr_valid) begin
            if (idx_q == pc_m1) begin
              idx_d = '0;
              st_d  = ST_ISSUE;
            end else begin
              idx_d = idx_q + CM_W'(1);
            end
          end
        end
      end
      ST_ISSUE: begin
        eng_start = 1'b1;
        st_d      = ST_WAIT;
      end
      ST_WAIT: begin
        if (eng_done) begin
          if (eng_err) begin
            res_d = RES_BUSERR;
            st_d  = ST_RECOV;
          end else if (eng_cnt != pc_cnt) begin
            res_d = RES_SHORT;
            st_d  = (pc_last && !more_q) ? ST_DONE : ST_ABORT;
          end else begin
            cnt_d = cnt_q + LEN_W'(pc_cnt);
            if (read_q) begin
              ld_rbuf = 1'b1;
              idx_d   = '0;
              st_d    = ST_UNLOAD;
            end else begin
              rem_d = rem_q - LEN_W'(pc_cnt);
              st_d  = pc_last ? ST_DONE : ST_LOAD;
            end
          end
        end else if (expired) begin
          res_d = RES_TIMEOUT;
          st_d  = ST_ABORT;
        end
      end
      ST_UNLOAD: begin
        rd_valid = 1'b1;
        if (idx_q == pc_m1) begin
          idx_d = '0;
          rem_d = rem_q - LEN_W'(pc_cnt);
          st_d  = pc_last ? ST_DONE : ST_LOAD;
        end else begin
          idx_d = idx_q + CM_W'(1);
        end
      end
      ST_ABORT: begin
        eng_abort = 1'b1;
        st_d      = ST_DONE;
      end
      ST_RECOV: begin
        eng_err_clr = 1'b1;
        eng_flush   = 1'b1;
        eng_sreset  = !bus_free;
        st_d        = ST_DONE;
      end
      ST_DONE: begin
        msg_done = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q  <= ST_IDLE;
      res_q <= RES_OK;
      rem_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
      rem_q <= rem_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      addr_q <= '0;
      ten_q  <= 1'b0;
      read_q <= 1'b0;
      more_q <= 1'b0;
    end else if (ld_msg) begin
      addr_q <= msg_addr;
      ten_q  <= msg_ten;
      read_q <= msg_read;
      more_q <= msg_more;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ref_addr_q <= '0;
      ref_ten_q  <= 1'b0;
    end else if (ld_ref) begin
      ref_addr_q <= msg_addr;
      ref_ten_q  <= msg_ten;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      rbuf_q <= '0;
    else if (ld_rbuf) rbuf_q <= eng_rbuf;
  end

  // write buffer lanes
  for (genvar l = 0; l < BUF_BYTES; l++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_we;
    assign lane_we = (st_q == ST_LOAD) && !read_q && wr_valid && (idx_q == CM_W'(l));
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)      lane_q <= '0;
      else if (lane_we) lane_q <= wr_data;
    end
    assign eng_wbuf[8*l +: 8] = lane_q;
  end

  assign rd_data    = rbuf_q[{idx_q, 3'b000} +: 8];
  assign eng_tct    = pc_m1;
  assign eng_chain  = !pc_last;
  assign eng_rstart = pc_last && more_q;
  assign eng_rw     = read_q;
  assign msg_status = res_q;
  assign msg_count  = cnt_q;

endmodule

// File: rtl/i2c_chunk_seq_chk.sv
module i2c_chunk_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_start,
  input logic       eng_abort,
  input logic       eng_err_clr,
  input logic       eng_sreset,
  input logic       msg_done,
  input logic [2:0] msg_status,
  input logic       rd_valid,
  input logic       wr_ready
);
  assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready));

  assert_sreset_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_sreset && !eng_err_clr) |=> (!eng_start && !msg_done));

  assert_abort_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |=> (msg_done && (msg_status != 3'd0)));

  assert_errclr_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err_clr |=> (msg_done && (msg_status == 3'd5)));

  assert_wait_after_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !msg_done);

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done);
endmodule

bind i2c_chunk_seq i2c_chunk_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_start(eng_start), .eng_abort(eng_abort),
  .eng_err_clr(eng_err_clr), .eng_sreset(eng_sreset), .msg_done(msg_done),
  .msg_status(msg_status), .rd_valid(rd_valid), .wr_ready(wr_ready)
);

// File: tb/i2c_chunk_seq_test.sv
`timescale 1ns/1ps
module i2c_chunk_seq_test;
  localparam int LEN_W = 8;
  localparam int BB    = 4;
  localparam int TOC   = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic msg_start, msg_first, msg_more, msg_ten, msg_read;
  logic [9:0] msg_addr;
  logic [LEN_W-1:0] msg_len;
  logic [7:0] wr_data;
  logic wr_valid, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, msg_done;
  logic [2:0] msg_status;
  logic [LEN_W-1:0] msg_count;
  logic eng_start, eng_chain, eng_rstart, eng_rw, eng_amode;
  logic [1:0] eng_tct;
  logic [7:0] eng_addr_lo, eng_addr_hi;
  logic [8*BB-1:0] eng_wbuf, eng_rbuf;
  logic eng_done, eng_err;
  logic [2:0] eng_cnt;
  logic bus_free, eng_abort, eng_flush, eng_err_clr, eng_sreset;

  i2c_chunk_seq #(.LEN_W(LEN_W), .BUF_BYTES(BB), .TIMEOUT_CYC(TOC)) uut (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_first(msg_first),
    .msg_more(msg_more), .msg_ten(msg_ten), .msg_read(msg_read), .msg_addr(msg_addr),
    .msg_len(msg_len), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .msg_done(msg_done), .msg_status(msg_status),
    .msg_count(msg_count), .eng_start(eng_start), .eng_tct(eng_tct), .eng_chain(eng_chain),
    .eng_rstart(eng_rstart), .eng_rw(eng_rw), .eng_amode(eng_amode),
    .eng_addr_lo(eng_addr_lo), .eng_addr_hi(eng_addr_hi), .eng_wbuf(eng_wbuf),
    .eng_done(eng_done), .eng_err(eng_err), .eng_cnt(eng_cnt), .eng_rbuf(eng_rbuf),
    .bus_free(bus_free), .eng_abort(eng_abort), .eng_flush(eng_flush),
    .eng_err_clr(eng_err_clr), .eng_sreset(eng_sreset)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  int cur_len, cur_seed;
  bit cur_more, cur_read, cur_ten;
  logic [9:0] cur_addr;
  int n_start, n_flush, n_sreset, n_abort, n_errclr;
  int chunk_i, off, rd_ptr, wr_ptr;
  int inj_short = -1, short_cnt = 0, inj_err = -1, inj_hang = -1;
  bit err_busy = 0, fix_on_reset = 0;
  int got_status, got_count;

  function automatic logic [7:0] wr_byte(int seed, int n);
    return 8'((seed + n * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] rd_byte(int seed, int n);
    return 8'(((seed * 5) ^ (n * 13)) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  assign wr_data  = wr_byte(cur_seed, wr_ptr);
  assign wr_valid = 1'b1;

  // write stream pointer
  initial begin
    wr_ptr = 0;
    forever begin
      bit take;
      @(negedge clk);
      take = wr_ready;
      @(posedge clk);
      #1;
      if (take) wr_ptr++;
    end
  end

  // strobe monitor and read data checker
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (eng_flush) n_flush++;
        if (eng_abort) n_abort++;
        if (eng_err_clr) n_errclr++;
        if (eng_sreset) begin
          n_sreset++;
          if (fix_on_reset) bus_free = 1'b1;
        end
        if (rd_valid) begin
          chk(rd_data == rd_byte(cur_seed, rd_ptr), "R6 read byte", int'(rd_data),
              int'(rd_byte(cur_seed, rd_ptr)));
          rd_ptr++;
        end
      end
    end
  end

  // bus engine model
  initial begin
    eng_done = 0; eng_err = 0; eng_cnt = '0; eng_rbuf = '0;
    forever begin
      @(negedge clk);
      if (rst_n && eng_start) begin
        int rem, ec, ci;
        logic [7:0] elo, ehi;
        rem = cur_len - off;
        ec  = (rem > BB) ? BB : rem;
        ci  = chunk_i;
        n_start++;
        chk(int'(eng_tct) == ec - 1, "R2 count field", int'(eng_tct), ec - 1);
        chk(eng_chain == (rem > BB), "R3 chain flag", int'(eng_chain), int'(rem > BB));
        chk(eng_rstart == (rem <= BB && cur_more), "R4 repeated start",
            int'(eng_rstart), int'(rem <= BB && cur_more));
        chk(eng_rw == cur_read, "R1 direction", int'(eng_rw), int'(cur_read));
        elo = cur_ten ? cur_addr[7:0] : {cur_addr[6:0], 1'b0};
        ehi = cur_ten ? {5'b11110, cur_addr[9:8], 1'b0} : 8'h00;
        chk(eng_amode == cur_ten, "R7 address mode", int'(eng_amode), int'(cur_ten));
        chk(eng_addr_lo == elo, "R7 low address", int'(eng_addr_lo), int'(elo));
        chk(eng_addr_hi == ehi, "R7 high address", int'(eng_addr_hi), int'(ehi));
        if (!cur_read) begin
          for (int k = 0; k < ec; k++)
            chk(eng_wbuf[8*k +: 8] == wr_byte(cur_seed, off + k), "R5 write lane",
                int'(eng_wbuf[8*k +: 8]), int'(wr_byte(cur_seed, off + k)));
        end
        for (int k = 0; k < BB; k++) eng_rbuf[8*k +: 8] = rd_byte(cur_seed, off + k);
        off += ec;
        chunk_i++;
        if (ci != inj_hang) begin
          repeat (2 + ci % 3) @(negedge clk);
          eng_done = 1'b1;
          eng_cnt  = 3'((ci == inj_short) ? short_cnt : ec);
          eng_err  = (ci == inj_err);
          if (ci == inj_err && err_busy) bus_free = 1'b0;
          @(negedge clk);
          eng_done = 1'b0;
          eng_err  = 1'b0;
        end
      end
    end
  end

  task automatic run_msg(bit first, bit more, bit ten, bit rd, int addr, int len, int seed);
    bit seen = 0;
    cur_len = len; cur_seed = seed; cur_more = more; cur_read = rd; cur_ten = ten;
    cur_addr = 10'(addr);
    n_start = 0; n_flush = 0; n_sreset = 0; n_abort = 0; n_errclr = 0;
    chunk_i = 0; off = 0; rd_ptr = 0; wr_ptr = 0;
    @(negedge clk);
    msg_first = first; msg_more = more; msg_ten = ten; msg_read = rd;
    msg_addr = 10'(addr); msg_len = LEN_W'(len); msg_start = 1'b1;
    @(negedge clk);
    msg_start = 1'b0;
    for (int t = 0; t < 500 && !seen; t++) begin
      if (msg_done) begin
        seen = 1;
        got_status = int'(msg_status);
        got_count  = int'(msg_count);
      end else @(negedge clk);
    end
    chk(seen, "R13 completion seen", int'(seen), 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; msg_start = 0; msg_first = 0; msg_more = 0; msg_ten = 0; msg_read = 0;
    msg_addr = '0; msg_len = '0; bus_free = 1; cur_seed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk(!msg_done && !eng_start && !wr_ready && !rd_valid, "R13 reset strobes", 0, 0);
    chk(msg_status == 3'd0, "R13 reset status", int'(msg_status), 0);

    // R1 R5 R9 R13: 7-bit writes, every length 1..9
    for (int len = 1; len <= 9; len++) begin
      run_msg(1, 0, 0, 0, 'h2A, len, len * 11);
      chk(got_status == 0, "R13 write status", got_status, 0);
      chk(got_count == len, "R13 write count", got_count, len);
      chk(n_start == (len + BB - 1) / BB, "R1 piece count", n_start, (len + BB - 1) / BB);
      chk(n_flush == 1, "R9 flush on free bus", n_flush, 1);
    end
    // R1 R6: reads, every length 1..9
    for (int len = 1; len <= 9; len++) begin
      run_msg(1, 0, 0, 1, 'h51, len, len * 17 + 1);
      chk(got_status == 0, "R13 read status", got_status, 0);
      chk(rd_ptr == len, "R6 read byte total", rd_ptr, len);
      chk(n_start == (len + BB - 1) / BB, "R1 read piece count", n_start, (len + BB - 1) / BB);
    end
    // R7: 10-bit address
    run_msg(1, 0, 1, 0, 'h2D7, 6, 40);
    chk(got_status == 0, "R7 ten-bit write", got_status, 0);
    run_msg(1, 0, 1, 1, 'h1C3, 2, 41);
    chk(got_status == 0, "R7 ten-bit read", got_status, 0);
    // R4: combined write then read
    run_msg(1, 1, 0, 0, 'h33, 5, 50);
    chk(got_status == 0, "R4 combined first", got_status, 0);
    run_msg(0, 0, 0, 1, 'h33, 7, 51);
    chk(got_status == 0, "R4 combined second", got_status, 0);
    chk(n_flush == 0, "R9 no check on non-first", n_flush, 0);
    // R8 rejections
    run_msg(1, 1, 1, 0, 'h155, 2, 52);
    run_msg(0, 0, 0, 0, 'h55, 2, 53);
    chk(got_status == 1, "R8 mode mismatch", got_status, 1);
    chk(n_start == 0, "R8 no start on mode mismatch", n_start, 0);
    run_msg(0, 0, 1, 0, 'h156, 2, 54);
    chk(got_status == 1, "R8 address mismatch", got_status, 1);
    run_msg(1, 0, 0, 0, 'h20, 0, 55);
    chk(got_status == 1, "R8 zero length", got_status, 1);
    run_msg(1, 0, 0, 0, 'h80, 3, 56);
    chk(got_status == 1, "R8 address range", got_status, 1);
    chk(n_start == 0, "R8 no start on range", n_start, 0);
    // R9 bus stuck, then recovered
    bus_free = 0; fix_on_reset = 0;
    run_msg(1, 0, 0, 0, 'h10, 3, 57);
    chk(got_status == 2, "R9 stuck status", got_status, 2);
    chk(n_sreset == 1, "R9 stuck soft reset", n_sreset, 1);
    chk(n_start == 0, "R9 stuck no start", n_start, 0);
    fix_on_reset = 1;
    run_msg(1, 0, 0, 0, 'h10, 3, 58);
    chk(got_status == 0, "R9 recovered status", got_status, 0);
    chk(n_sreset == 1 && n_flush == 0, "R9 recovered strobes", n_sreset * 10 + n_flush, 10);
    fix_on_reset = 0; bus_free = 1;
    // R10 short counts
    inj_short = 0; short_cnt = 2;
    run_msg(1, 0, 0, 0, 'h11, 6, 59);
    chk(got_status == 3, "R10 short status", got_status, 3);
    chk(n_abort == 1, "R10 abort mid message", n_abort, 1);
    chk(got_count == 0, "R13 short count", got_count, 0);
    inj_short = 1; short_cnt = 1;
    run_msg(1, 0, 0, 0, 'h11, 6, 60);
    chk(n_abort == 0, "R10 no abort on final piece", n_abort, 0);
    chk(got_count == 4, "R13 partial count", got_count, 4);
    inj_short = 0; short_cnt = 1;
    run_msg(1, 1, 0, 1, 'h11, 3, 61);
    chk(got_status == 3 && n_abort == 1, "R10 abort before repeated start", n_abort, 1);
    inj_short = -1;
    // R11 bus error
    inj_err = 0; err_busy = 0;
    run_msg(1, 0, 0, 0, 'h12, 2, 62);
    chk(got_status == 5, "R11 error status", got_status, 5);
    chk(n_errclr == 1 && n_flush == 2, "R11 clear and flush", n_errclr * 10 + n_flush, 12);
    chk(n_sreset == 0, "R11 no reset on free bus", n_sreset, 0);
    err_busy = 1;
    run_msg(1, 0, 0, 1, 'h12, 5, 63);
    chk(got_status == 5 && n_sreset == 1, "R11 reset on busy bus", n_sreset, 1);
    inj_err = -1; err_busy = 0; bus_free = 1;
    // R12 timeout
    inj_hang = 0;
    run_msg(1, 0, 0, 1, 'h13, 3, 64);
    chk(got_status == 4, "R12 timeout status", got_status, 4);
    chk(n_abort == 1 && n_start == 1, "R12 timeout abort", n_abort, 1);
    inj_hang = -1;
    run_msg(1, 0, 0, 0, 'h13, 4, 65);
    chk(got_status == 0, "R12 clean after timeout", got_status, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule